// File: doc/BRIEF.md
# Registered DIMM Control Word Sequencer

This block drives the programming of the buffer chip on a registered DDR3 memory module. An initialization request walks the chip selects of a channel two at a time. For every pair that has at least one chip select populated, it computes sixteen 4-bit control words in turn and sends fourteen of them as command-bus writes. Each write carries the word number and the word data spread over the bank and low address lines. Each word is preceded by a programmable mode-register wait, and the whole sequence is framed by an initial wait, a clock-lock wait and a final stabilization wait. A separate frequency-change request sends only the speed word to each populated pair.

Commands leave the block on a valid/ready interface. `cmd_valid` rises once the pre-word wait has elapsed. It then stays high, with `cmd_bank`, `cmd_addr` and `cmd_cs` held constant, until `cmd_ready` is sampled high on a rising clock edge. That edge completes the transfer. The consumer may hold `cmd_ready` low for any number of cycles, and may also keep it high all the time. While `cmd_valid` is low, the fields read zero and no transfer takes place. The configuration inputs must stay stable while `busy` is high. Every wait length is a parameter given in clock cycles.

Top module: `rdimm_cw_seq`

## Requirements
- R1: Pairs are visited in ascending order, from chip select 0 upward in steps of 2. A pair is used only when one or both of its bits in `cs_present` are set. Each command targets a populated pair.
- R2: While a command is offered, `cmd_cs` equals 3 shifted left by the pair's first chip select n. The slot used for per-slot inputs is n/2.
- R3: In an initialization, each used pair receives words 0 to 15 in ascending order, except words 6 and 7, which are never sent. The pre-word wait is still spent for words 6 and 7.
- R4: Word number bit 3 drives `cmd_bank[2]` and word number bits 2..0 drive `cmd_addr[2:0]`. Data bits 3..2 drive `cmd_bank[1:0]` and data bits 1..0 drive `cmd_addr[4:3]`. Every other address bit is 0.
- R5: Once raised, `cmd_valid` and the command fields hold unchanged until `cmd_ready` is sampled high.
- R6: Word 0 is 0x2. Word 1 is 0xC for a single-rank slot and 0 otherwise. Words 2, 3, 4, 5 and 8 come from the slot's nibble in `cfg_w2`, `cfg_w3`, `cfg_w4`, `cfg_w5` and `cfg_w8` (bits 4s+3..4s for slot s). Word 11 is `volt_code`. In an initialization, all other words are 0.
- R7: Word 9 is 0x9 when three conditions hold together: `pd_partial` is 1, the slot is single-rank, and any bit of `slot_dual` or `slot_quad` is set. In every other case word 9 is 0xD.
- R8: After an accepted `start_init`, at least T_INIT+T_LOCK+T_MRD cycles pass before the first transfer. Consecutive transfers are at least T_MRD cycles apart. `done` comes at least T_STAB cycles after the last transfer, or at least T_INIT+T_LOCK+T_STAB cycles after the start when no pair is used.
- R9: An accepted `start_freq` sends only word 10 to each used pair. The data is `speed_code`, where codes 0 to 4 stand for 800, 1066, 1333, 1600 and 1866.
- R10: A `start_freq` with `speed_code` above 4 produces a one-cycle `speed_err` pulse. It sends nothing and produces no `done`.
- R11: A start strobe is acted on only while `busy` is low. Strobes that arrive while busy are ignored.
- R12: `done` is a single-cycle pulse at the end of every accepted sequence, including a sequence that has no used pair.
- R13: After reset, `cmd_valid`, `cmd_cs`, `busy`, `done` and `speed_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_init | input | 1 | Request for a full control-word initialization |
| start_freq | input | 1 | Request to send the speed word only |
| cs_present | input | NUM_CS | Populated chip selects |
| slot_single | input | NUM_CS/2 | Slot holds a single-rank module |
| slot_dual | input | NUM_CS/2 | Slot holds a dual-rank module |
| slot_quad | input | NUM_CS/2 | Slot holds a quad-rank module |
| pd_partial | input | 1 | Partial power-down mode selected |
| speed_code | input | 3 | Speed grade code |
| volt_code | input | 4 | Voltage code, sent as word 11 |
| cfg_w2 | input | 2*NUM_CS | Per-slot word 2 values |
| cfg_w3 | input | 2*NUM_CS | Per-slot word 3 values |
| cfg_w4 | input | 2*NUM_CS | Per-slot word 4 values |
| cfg_w5 | input | 2*NUM_CS | Per-slot word 5 values |
| cfg_w8 | input | 2*NUM_CS | Per-slot word 8 values |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_bank | output | 3 | Bank field of the command |
| cmd_addr | output | ADDR_W | Address field of the command |
| cmd_cs | output | NUM_CS | Chip-select mask of the command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete pulse |
| speed_err | output | 1 | Unsupported speed code pulse |

## Verification
The initialization is driven through all sixteen occupancy patterns of the four pairs. Each used pair is populated on its low bit, its high bit or both, which shows whether the pair test looks at both bits and whether an empty pair is truly skipped. The rank flags, power-down mode and per-slot values change from run to run, so that word 1 and both outcomes of word 9 come up on different slots, and a slot or nibble mix-up shows as a wrong value. The frequency-change path is run with all eight speed codes to separate the valid codes from the rejected ones. A randomized ready pattern stalls transfers, and a start is repeated during a busy run to show it has no effect.

// File: rtl/rdimm_cw_pkg.sv
package rdimm_cw_pkg;
  localparam int          CW_W        = 4;
  localparam int          BANK_W      = 3;
  localparam logic [3:0]  WORD_SPEED  = 4'd10;
  localparam logic [3:0]  WORD_LAST   = 4'd15;
  localparam logic [2:0]  SPEED_MAX   = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WINIT,
    ST_WLOCK,
    ST_SCAN,
    ST_GAP,
    ST_SEND,
    ST_NEXT,
    ST_STAB,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/cw_timer.sv
module cw_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R8: a loaded wait never ends early
  a_r8_no_early_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len > 1) |=> !expired);
endmodule

// File: rtl/cw_value.sv
module cw_value #(
  parameter int NSLOT  = 4,
  parameter int SLOT_W = 2
) (
  input  logic [3:0]         word,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               freq_mode,
  input  logic [2:0]         speed,
  input  logic [NSLOT-1:0]   sr,
  input  logic [NSLOT-1:0]   dr,
  input  logic [NSLOT-1:0]   qr,
  input  logic               pd_partial,
  input  logic [4*NSLOT-1:0] cw2,
  input  logic [4*NSLOT-1:0] cw3,
  input  logic [4*NSLOT-1:0] cw4,
  input  logic [4*NSLOT-1:0] cw5,
  input  logic [4*NSLOT-1:0] cw8,
  input  logic [3:0]         volt,
  output logic [3:0]         value
);
  localparam int IDX_W = SLOT_W + 2;

  logic [IDX_W-1:0] base;
  logic             single;
  logic             multi_on_channel;

  assign base             = {slot, 2'b00};
  assign single           = sr[slot];
  assign multi_on_channel = (|dr) || (|qr);

  always_comb begin
    value = 4'h0;
    unique case (word)
      4'd0:  value = 4'h2;
      4'd1:  value = single ? 4'hC : 4'h0;
      4'd2:  value = cw2[base +: 4];
      4'd3:  value = cw3[base +: 4];
      4'd4:  value = cw4[base +: 4];
      4'd5:  value = cw5[base +: 4];
      4'd8:  value = cw8[base +: 4];
      4'd9:  value = (pd_partial && single && multi_on_channel) ? 4'h9 : 4'hD;
      4'd10: value = freq_mode ? {1'b0, speed} : 4'h0;
      4'd11: value = volt;
      default: value = 4'h0;
    endcase
  end
endmodule

// File: rtl/cw_encode.sv
module cw_encode #(
  parameter int ADDR_W = 16
) (
  input  logic [3:0]        word,
  input  logic [3:0]        data,
  output logic [2:0]        bank,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    addr      = '0;
    addr[2:0] = word[2:0];
    addr[4:3] = data[1:0];
    bank      = {word[3], data[3:2]};
  end
endmodule

// File: rtl/rdimm_cw_seq.sv
module rdimm_cw_seq
  import rdimm_cw_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 16,
  parameter int T_INIT = 800,
  parameter int T_LOCK = 600,
  parameter int T_MRD  = 800,
  parameter int T_STAB = 600
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_init,
  input  logic                  start_freq,
  input  logic [NUM_CS-1:0]     cs_present,
  input  logic [NUM_CS/2-1:0]   slot_single,
  input  logic [NUM_CS/2-1:0]   slot_dual,
  input  logic [NUM_CS/2-1:0]   slot_quad,
  input  logic                  pd_partial,
  input  logic [2:0]            speed_code,
  input  logic [3:0]            volt_code,
  input  logic [2*NUM_CS-1:0]   cfg_w2,
  input  logic [2*NUM_CS-1:0]   cfg_w3,
  input  logic [2*NUM_CS-1:0]   cfg_w4,
  input  logic [2*NUM_CS-1:0]   cfg_w5,
  input  logic [2*NUM_CS-1:0]   cfg_w8,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [BANK_W-1:0]     cmd_bank,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic [NUM_CS-1:0]     cmd_cs,
  output logic                  busy,
  output logic                  done,
  output logic                  speed_err
);
  localparam int NPAIR  = NUM_CS / 2;
  localparam int PAIR_W = $clog2(NPAIR + 1);
  localparam int SLOT_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int MAX_A  = (T_INIT > T_LOCK) ? T_INIT : T_LOCK;
  localparam int MAX_B  = (T_MRD > T_STAB) ? T_MRD : T_STAB;
  localparam int MAXT   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = (MAXT > 0) ? $clog2(MAXT + 1) : 1;

  seq_state_t         state;
  logic [PAIR_W-1:0]  pair_idx;
  logic [3:0]         word;
  logic               freq_q;
  logic [2:0]         spd_q;
  logic               err_q;

  logic [NPAIR-1:0]   pair_active;
  logic [SLOT_W-1:0]  slot;
  logic               scan_end;
  logic               cur_active;
  logic               pair_last_word;
  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_len;
  logic               tmr_exp;
  logic [3:0]         word_val;
  logic [BANK_W-1:0]  enc_bank;
  logic [ADDR_W-1:0]  enc_addr;
  logic               start_ok_freq;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    assign pair_active[g] = |cs_present[2*g +: 2];
  end

  assign slot           = pair_idx[SLOT_W-1:0];
  assign scan_end       = (pair_idx == PAIR_W'(NPAIR));
  assign cur_active     = !scan_end && pair_active[slot];
  assign pair_last_word = freq_q || (word == WORD_LAST);
  assign start_ok_freq  = start_freq && (speed_code <= SPEED_MAX);

  // timer load requests and the length for each wait
  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (state)
      ST_IDLE: if (start_init) begin
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(T_INIT);
      end
      ST_WINIT: if (tmr_exp) begin
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(T_LOCK);
      end
      ST_SCAN: begin
        if (scan_end && !freq_q) begin
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(T_STAB);
        end else if (cur_active) begin
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(T_MRD);
        end
      end
      ST_NEXT: if (!pair_last_word) begin
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(T_MRD);
      end
      default: ;
    endcase
  end

  cw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pair_idx <= '0;
      word     <= '0;
      freq_q   <= 1'b0;
      spd_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          pair_idx <= '0;
          if (start_init) begin
            freq_q <= 1'b0;
            state  <= ST_WINIT;
          end else if (start_ok_freq) begin
            freq_q <= 1'b1;
            spd_q  <= speed_code;
            state  <= ST_SCAN;
          end else if (start_freq) begin
            err_q <= 1'b1;
          end
        end
        ST_WINIT: if (tmr_exp) state <= ST_WLOCK;
        ST_WLOCK: if (tmr_exp) state <= ST_SCAN;
        ST_SCAN: begin
          if (scan_end) begin
            state <= freq_q ? ST_DONE : ST_STAB;
          end else if (cur_active) begin
            word  <= freq_q ? WORD_SPEED : 4'd0;
            state <= ST_GAP;
          end else begin
            pair_idx <= pair_idx + 1'b1;
          end
        end
        ST_GAP: if (tmr_exp) begin
          if (!freq_q && word[3:1] == 3'b011) state <= ST_NEXT;
          else                                 state <= ST_SEND;
        end
        ST_SEND: if (cmd_ready) state <= ST_NEXT;
        ST_NEXT: begin
          if (pair_last_word) begin
            pair_idx <= pair_idx + 1'b1;
            state    <= ST_SCAN;
          end else begin
            word  <= word + 1'b1;
            state <= ST_GAP;
          end
        end
        ST_STAB: if (tmr_exp) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  cw_value #(.NSLOT(NPAIR), .SLOT_W(SLOT_W)) u_value (
    .word       (word),
    .slot       (slot),
    .freq_mode  (freq_q),
    .speed      (spd_q),
    .sr         (slot_single),
    .dr         (slot_dual),
    .qr         (slot_quad),
    .pd_partial (pd_partial),
    .cw2        (cfg_w2),
    .cw3        (cfg_w3),
    .cw4        (cfg_w4),
    .cw5        (cfg_w5),
    .cw8        (cfg_w8),
    .volt       (volt_code),
    .value      (word_val)
  );

  cw_encode #(.ADDR_W(ADDR_W)) u_encode (
    .word (word),
    .data (word_val),
    .bank (enc_bank),
    .addr (enc_addr)
  );

  assign cmd_valid = (state == ST_SEND);
  assign cmd_bank  = cmd_valid ? enc_bank : '0;
  assign cmd_addr  = cmd_valid ? enc_addr : '0;
  assign cmd_cs    = cmd_valid ? (NUM_CS'(3) << {pair_idx, 1'b0}) : '0;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign speed_err = err_q;

  // R5: an offered command stays put until taken
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_bank) &&
                                   $stable(cmd_addr) && $stable(cmd_cs)));
  // R3: words 6 and 7 never appear on the bus
  a_r3_skip_six_seven: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_bank[2] || cmd_addr[2:1] != 2'b11));
  // R4: only the five low address bits may carry information
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr >> 5) == '0);
  // R2: a command addresses exactly one pair
  a_r2_two_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones(cmd_cs) == 2);
  // R1: only populated pairs are addressed
  a_r1_populated: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_cs & cs_present) != '0);
  // R9: a frequency change carries word 10 only
  a_r9_speed_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && freq_q) |-> (cmd_bank[2] && cmd_addr[2:0] == 3'b010));
  // R12: completion is one cycle wide
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: a rejected speed leaves the block idle
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    speed_err |-> (!busy && !cmd_valid));
endmodule

// File: tb/tb_rdimm_cw_seq.sv
module tb_rdimm_cw_seq;
  localparam int CLK_NS = 10;
  localparam int NCS    = 8;
  localparam int NSL    = NCS / 2;
  localparam int AW     = 16;
  localparam int TI     = 5;
  localparam int TL     = 3;
  localparam int TM     = 4;
  localparam int TS     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_init = 1'b0, start_freq = 1'b0;
  logic [NCS-1:0] cs_present = '0;
  logic [NSL-1:0] sr = '0, dr = '0, qr = '0;
  logic pd = 1'b0;
  logic [2:0] spd = '0;
  logic [3:0] volt = '0;
  logic [4*NSL-1:0] w2 = '0, w3 = '0, w4 = '0, w5 = '0, w8 = '0;
  logic cmd_valid, cmd_ready, busy, done, speed_err;
  logic [2:0] cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic [NCS-1:0] cmd_cs;

  rdimm_cw_seq #(.NUM_CS(NCS), .ADDR_W(AW), .T_INIT(TI), .T_LOCK(TL),
                 .T_MRD(TM), .T_STAB(TS)) dut (
    .clk(clk), .rst_n(rst_n), .start_init(start_init), .start_freq(start_freq),
    .cs_present(cs_present), .slot_single(sr), .slot_dual(dr), .slot_quad(qr),
    .pd_partial(pd), .speed_code(spd), .volt_code(volt),
    .cfg_w2(w2), .cfg_w3(w3), .cfg_w4(w4), .cfg_w5(w5), .cfg_w8(w8),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_cs(cmd_cs), .busy(busy), .done(done),
    .speed_err(speed_err));

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: drives ready, records transfers, done and error pulses
  logic [7:0] lfsr = 8'hA5;
  logic [2:0] rec_bank [0:255];
  logic [AW-1:0] rec_addr [0:255];
  logic [NCS-1:0] rec_cs [0:255];
  int rec_t [0:255];
  int n_rec = 0, n_done = 0, n_err = 0, last_done_t = 0, dbl_done = 0, hold_fail = 0;
  logic pv = 0, pr = 0, pdn = 0;
  logic [2:0] sb;
  logic [AW-1:0] sa;
  logic [NCS-1:0] sc;

  initial cmd_ready = 1'b0;

  always @(negedge clk) begin
    if (pv && !pr) begin
      if (!cmd_valid || cmd_bank !== sb || cmd_addr !== sa || cmd_cs !== sc)
        hold_fail++;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready = rst_n && (lfsr[0] | lfsr[1]);
    if (cmd_valid && cmd_ready) begin
      rec_bank[n_rec % 256] = cmd_bank;
      rec_addr[n_rec % 256] = cmd_addr;
      rec_cs[n_rec % 256]   = cmd_cs;
      rec_t[n_rec % 256]    = cyc;
      n_rec++;
    end
    if (done) begin
      n_done++;
      last_done_t = cyc;
      if (pdn) dbl_done++;
    end
    pdn = done;
    if (speed_err) n_err++;
    pv = cmd_valid; pr = cmd_ready;
    sb = cmd_bank; sa = cmd_addr; sc = cmd_cs;
  end

  function automatic logic [3:0] exp_val(input int w, input int s, input bit fm);
    case (w)
      0: return 4'h2;
      1: return sr[s] ? 4'hC : 4'h0;
      2: return w2[s*4 +: 4];
      3: return w3[s*4 +: 4];
      4: return w4[s*4 +: 4];
      5: return w5[s*4 +: 4];
      8: return w8[s*4 +: 4];
      9: return (pd && sr[s] && (dr != 0 || qr != 0)) ? 4'h9 : 4'hD;
      10: return fm ? {1'b0, spd} : 4'h0;
      11: return volt;
      default: return 4'h0;
    endcase
  endfunction

  task automatic check_entry(input int idx, input int p, input int w, input bit fm);
    logic [3:0] v;
    logic [2:0] eb;
    logic [AW-1:0] ea;
    string rq;
    v  = exp_val(w, p, fm);
    eb = {w[3], v[3:2]};
    ea = '0;
    ea[2:0] = w[2:0];
    ea[4:3] = v[1:0];
    rq = fm ? "R9/R4" : (w == 9 ? "R7/R4" : "R6/R4/R3");
    chk(rec_cs[idx % 256] == NCS'(3 << (2*p)), "R2", "cs mask",
        int'(rec_cs[idx % 256]), 3 << (2*p));
    chk(rec_bank[idx % 256] == eb, rq, $sformatf("bank pair %0d word %0d", p, w),
        int'(rec_bank[idx % 256]), int'(eb));
    chk(rec_addr[idx % 256] == ea, rq, $sformatf("addr pair %0d word %0d", p, w),
        int'(rec_addr[idx % 256]), int'(ea));
  endtask

  task automatic wait_end(input int d0, input int e0);
    int guard = 0;
    while (n_done == d0 && n_err == e0 && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    if (guard >= 20000) chk(1'b0, "R12", "run watchdog", guard, 0);
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_init(input bit restart);
    int base, d0, t0, idx, got;
    base = n_rec; d0 = n_done;
    @(negedge clk);
    start_init = 1'b1; t0 = cyc;
    @(negedge clk);
    start_init = 1'b0;
    if (restart) begin
      repeat (30) @(negedge clk);
      start_init = 1'b1; start_freq = 1'b1;
      @(negedge clk);
      start_init = 1'b0; start_freq = 1'b0;
    end
    wait_end(d0, n_err);
    got = n_rec - base;
    idx = 0;
    for (int p = 0; p < NSL; p++) begin
      if (cs_present[2*p +: 2] != 0) begin
        for (int w = 0; w < 16; w++) begin
          if (w != 6 && w != 7) begin
            if (idx < got) check_entry(base + idx, p, w, 1'b0);
            idx++;
          end
        end
      end
    end
    chk(got == idx, restart ? "R11" : "R1", "transfer count", got, idx);
    chk(n_done - d0 == 1, restart ? "R11" : "R12", "done pulses", n_done - d0, 1);
    if (got > 0) begin
      chk(rec_t[base % 256] - t0 >= TI + TL + TM, "R8", "first word delay",
          rec_t[base % 256] - t0, TI + TL + TM);
      for (int i = 1; i < got; i++) begin
        chk(rec_t[(base + i) % 256] - rec_t[(base + i - 1) % 256] >= TM, "R8",
            "word spacing", rec_t[(base + i) % 256] - rec_t[(base + i - 1) % 256], TM);
      end
      chk(last_done_t - rec_t[(base + got - 1) % 256] >= TS, "R8", "stabilize wait",
          last_done_t - rec_t[(base + got - 1) % 256], TS);
    end else begin
      chk(last_done_t - t0 >= TI + TL + TS, "R8", "empty run length",
          last_done_t - t0, TI + TL + TS);
    end
  endtask

  task automatic run_freq(input logic [2:0] code);
    int base, d0, e0, idx, got;
    base = n_rec; d0 = n_done; e0 = n_err;
    @(negedge clk);
    spd = code;
    start_freq = 1'b1;
    @(negedge clk);
    start_freq = 1'b0;
    wait_end(d0, e0);
    got = n_rec - base;
    if (code <= 3'd4) begin
      idx = 0;
      for (int p = 0; p < NSL; p++) begin
        if (cs_present[2*p +: 2] != 0) begin
          if (idx < got) check_entry(base + idx, p, 10, 1'b1);
          idx++;
        end
      end
      chk(got == idx, "R9", "speed word count", got, idx);
      chk(n_done - d0 == 1, "R12", "done after speed change", n_done - d0, 1);
      chk(n_err == e0, "R10", "no error on valid code", n_err - e0, 0);
    end else begin
      chk(got == 0, "R10", "sends on bad code", got, 0);
      chk(n_done == d0, "R10", "done on bad code", n_done - d0, 0);
      chk(n_err - e0 == 1, "R10", "error pulses", n_err - e0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset values
    chk(cmd_valid == 0, "R13", "valid in reset", int'(cmd_valid), 0);
    chk(cmd_cs == 0, "R13", "cs in reset", int'(cmd_cs), 0);
    chk(busy == 0 && done == 0 && speed_err == 0, "R13", "status in reset",
        int'({busy, done, speed_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 24; k++) begin
      logic [NCS-1:0] m;
      m = '0;
      for (int p = 0; p < NSL; p++) begin
        if (k[p]) m[2*p +: 2] = ((k + p) % 3 == 0) ? 2'b01 :
                                ((k + p) % 3 == 1) ? 2'b10 : 2'b11;
      end
      cs_present = m;
      sr = 4'(k * 5 + 1);
      dr = 4'(k * 3) & ~sr;
      qr = k[2] ? (4'b1000 & ~sr & ~dr) : 4'b0000;
      pd = k[0] ^ k[1];
      volt = 4'(k * 7 + 3);
      for (int s = 0; s < NSL; s++) begin
        w2[s*4 +: 4] = 4'(k + s * 3 + 1);
        w3[s*4 +: 4] = 4'(k * 2 + s * 5 + 2);
        w4[s*4 +: 4] = 4'(k + s * 7 + 3);
        w5[s*4 +: 4] = 4'(k * 3 + s + 4);
        w8[s*4 +: 4] = 4'(k * 5 + s * 11 + 5);
      end
      run_init(k == 7);
    end

    cs_present = 8'h62;
    for (int c = 0; c < 8; c++) run_freq(3'(c));
    cs_present = 8'hFF;
    run_freq(3'd3);
    cs_present = 8'h00;
    run_freq(3'd1);

    chk(hold_fail == 0, "R5", "offer changed before accept", hold_fail, 0);
    chk(dbl_done == 0, "R12", "done wider than a cycle", dbl_done, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule